// File: doc/BRIEF.md
# Speculative/Committed Store Buffer

This block holds stores after address translation and before the data cache. Each store carries a physical address, 64 bits of data and a byte-enable mask. It first waits in a speculative queue. There it cannot touch memory, and a single flush pulse drops it. When the retirement logic signals that the oldest pending store has retired, that store moves into a committed queue. Only the committed queue drives the data-cache write port, and it issues one write at a time, oldest first.

Loads do not wait. A combinational lookup port takes a load address and byte mask and searches both queues. It returns the bytes of the newest store that writes each lane, and reports whether the load is fully served, partly served (the load must stall) or not served at all. An `empty` output lets fence-like operations wait until every buffered store has reached the cache.

The store input is a valid/ready stream: a store is taken on any cycle with `in_valid` and `in_ready` both high, and `in_ready` falls while the speculative queue is full. The cache write port is a valid/ready stream too: once `wr_valid` is raised, address, data and mask stay fixed until `wr_ready` is seen high, and the entry leaves only on that cycle.

Top module: `store_buffer`

## Requirements
- R1: A synchronous active-high reset empties both queues. After it, `empty`=1, `wr_valid`=0, `in_ready`=1 and `commit_ready`=1.
- R2: An accepted store never appears on the write port while it is speculative. `wr_valid` is 0 whenever the committed queue holds nothing.
- R3: A `flush` pulse empties the speculative queue by the next cycle, and a store offered in the flush cycle is dropped. The committed queue is untouched and keeps draining.
- R4: `commit_req` with `commit_ready` high moves the oldest speculative store into the committed queue. It shows on the write port from the next cycle if it is the oldest committed entry. `commit_ready` is 0 while the committed queue holds DEPTH (4) entries, and a request then moves nothing.
- R5: While the speculative queue holds DEPTH entries, `in_ready` is 0 and an offered store is not taken.
- R6: Committed stores leave in commit order, one per accepted handshake. While `wr_valid`=1 and `wr_ready`=0, `wr_addr`, `wr_data` and `wr_be` hold their values.
- R7: The lookup matches a store when address bits [ADDR_W-1:3] are equal, so the 8-byte word is compared and the low three bits are ignored. Byte lane i is data bits [8i+7:8i] and is enabled by mask bit i. For each lane the youngest speculative store wins; if none, the youngest committed store wins. Lanes served by no store, or not requested, read as zero.
- R8: `ld_hit`=1 when every lane in a nonzero `ld_be` is served. `ld_stall`=1 when some lanes are served but not all. Both are 0 when none are served. The two are never high together.
- R9: `empty`=1 exactly when both queues hold nothing.
- R10: When `commit_req` and `flush` come in the same cycle, the oldest speculative store still moves to the committed queue, and the remaining speculative stores are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Translated store offered |
| in_ready | output | 1 | Speculative queue can accept |
| in_addr | input | ADDR_W | Physical store address |
| in_data | input | DATA_W | Store data, lane-aligned |
| in_be | input | DATA_W/8 | Store byte mask |
| flush | input | 1 | Drop all speculative stores |
| commit_req | input | 1 | Oldest speculative store has retired |
| commit_ready | output | 1 | Committed queue has room |
| wr_valid | output | 1 | Cache write pending |
| wr_ready | input | 1 | Cache accepts the write |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_be | output | DATA_W/8 | Write byte mask |
| ld_addr | input | ADDR_W | Load address to look up |
| ld_be | input | DATA_W/8 | Load byte mask |
| ld_data | output | DATA_W | Forwarded bytes, zero where not served |
| ld_hit | output | 1 | Load fully served |
| ld_stall | output | 1 | Load partly served, must stall |
| empty | output | 1 | No store buffered anywhere |

## Verification
The bench targets the overlap of lanes from three stores in one word: committed, older speculative and younger speculative. A priority bug there returns stale bytes instead of the newest data. It fills the committed queue and then requests a commit. A design that ignores `commit_ready` would overwrite a committed store or move the speculative one, so it would outlive the following flush. It raises flush and commit in the same cycle, where a wrong ordering either loses the retiring store or keeps the squashed one. It also stalls the write port for several cycles, where a design that changes the write fields or pops early would skip or corrupt a write.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  parameter int ADDR_W = 32;
  parameter int DATA_W = 64;
  localparam int BE_W  = DATA_W / 8;
  localparam int OFF_W = $clog2(BE_W);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
  } st_entry_t;
endpackage

// File: rtl/stbuf_queue.sv
module stbuf_queue
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  push,
  input  st_entry_t             push_ent,
  input  logic                  pop,
  output st_entry_t             head_ent,
  output st_entry_t [DEPTH-1:0] slots,
  output logic [PW-1:0]         head_idx,
  output logic [CW-1:0]         count,
  output logic                  full,
  output logic                  empty
);
  logic [PW-1:0] tail_idx;

  assign tail_idx = head_idx + count[PW-1:0];
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign head_ent = slots[head_idx];

  always_ff @(posedge clk) begin
    if (push) slots[tail_idx] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_idx <= '0;
      count    <= '0;
    end else begin
      if (pop) head_idx <= head_idx + PW'(1);
      if (clear) count <= '0;
      else       count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  st_entry_t [DEPTH-1:0] sq_slots,
  input  logic [PW-1:0]         sq_head,
  input  logic [CW-1:0]         sq_cnt,
  input  st_entry_t [DEPTH-1:0] cq_slots,
  input  logic [PW-1:0]         cq_head,
  input  logic [CW-1:0]         cq_cnt,
  input  logic [ADDR_W-1:0]     ld_addr,
  input  logic [BE_W-1:0]       ld_be,
  output logic [DATA_W-1:0]     fwd_data,
  output logic                  hit,
  output logic                  stall
);
  logic [DATA_W-1:0] merged;
  logic [BE_W-1:0]   cov;
  logic [BE_W-1:0]   used;

  // Oldest to youngest, committed first, so later writes override earlier.
  always_comb begin
    merged = '0;
    cov    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (CW'(k) < cq_cnt &&
          cq_slots[cq_head + PW'(k)].addr[ADDR_W-1:OFF_W] == ld_addr[ADDR_W-1:OFF_W]) begin
        for (int b = 0; b < BE_W; b++) begin
          if (cq_slots[cq_head + PW'(k)].be[b]) begin
            merged[b*8 +: 8] = cq_slots[cq_head + PW'(k)].data[b*8 +: 8];
            cov[b] = 1'b1;
          end
        end
      end
    end
    for (int k = 0; k < DEPTH; k++) begin
      if (CW'(k) < sq_cnt &&
          sq_slots[sq_head + PW'(k)].addr[ADDR_W-1:OFF_W] == ld_addr[ADDR_W-1:OFF_W]) begin
        for (int b = 0; b < BE_W; b++) begin
          if (sq_slots[sq_head + PW'(k)].be[b]) begin
            merged[b*8 +: 8] = sq_slots[sq_head + PW'(k)].data[b*8 +: 8];
            cov[b] = 1'b1;
          end
        end
      end
    end
  end

  assign used = cov & ld_be;

  always_comb begin
    for (int b = 0; b < BE_W; b++)
      fwd_data[b*8 +: 8] = used[b] ? merged[b*8 +: 8] : 8'h00;
  end

  assign hit   = (ld_be != '0) && (used == ld_be);
  assign stall = (used != '0) && (used != ld_be);
endmodule

// File: rtl/store_buffer.sv
module store_buffer
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BE_W-1:0]   in_be,
  input  logic              flush,
  input  logic              commit_req,
  output logic              commit_ready,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [BE_W-1:0]   wr_be,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BE_W-1:0]   ld_be,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_hit,
  output logic              ld_stall,
  output logic              empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  st_entry_t             in_ent, sq_head_ent, cq_head_ent;
  st_entry_t [DEPTH-1:0] sq_slots, cq_slots;
  logic [PW-1:0]         sq_head, cq_head;
  logic [CW-1:0]         sq_count, cq_count;
  logic                  sq_full, sq_empty, cq_full, cq_empty;
  logic                  st_push, commit_fire, wr_fire;

  assign in_ent       = '{addr: in_addr, data: in_data, be: in_be};
  assign in_ready     = !sq_full;
  assign st_push      = in_valid && in_ready;
  assign commit_ready = !cq_full;
  assign commit_fire  = commit_req && !cq_full && !sq_empty;
  assign wr_valid     = !cq_empty;
  assign wr_fire      = wr_valid && wr_ready;
  assign wr_addr      = cq_head_ent.addr;
  assign wr_data      = cq_head_ent.data;
  assign wr_be        = cq_head_ent.be;
  assign empty        = sq_empty && cq_empty;

  stbuf_queue #(.DEPTH(DEPTH)) u_spec (
    .clk(clk), .rst(rst), .clear(flush),
    .push(st_push), .push_ent(in_ent), .pop(commit_fire),
    .head_ent(sq_head_ent), .slots(sq_slots), .head_idx(sq_head),
    .count(sq_count), .full(sq_full), .empty(sq_empty)
  );

  stbuf_queue #(.DEPTH(DEPTH)) u_cmt (
    .clk(clk), .rst(rst), .clear(1'b0),
    .push(commit_fire), .push_ent(sq_head_ent), .pop(wr_fire),
    .head_ent(cq_head_ent), .slots(cq_slots), .head_idx(cq_head),
    .count(cq_count), .full(cq_full), .empty(cq_empty)
  );

  stbuf_fwd #(.DEPTH(DEPTH)) u_fwd (
    .sq_slots(sq_slots), .sq_head(sq_head), .sq_cnt(sq_count),
    .cq_slots(cq_slots), .cq_head(cq_head), .cq_cnt(cq_count),
    .ld_addr(ld_addr), .ld_be(ld_be),
    .fwd_data(ld_data), .hit(ld_hit), .stall(ld_stall)
  );
endmodule

// File: rtl/store_buffer_chk.sv
module store_buffer_chk
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              flush,
  input logic              commit_req,
  input logic              commit_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [BE_W-1:0]   wr_be,
  input logic              ld_hit,
  input logic              ld_stall,
  input logic              empty,
  input logic [CW-1:0]     sq_count,
  input logic [CW-1:0]     cq_count
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (empty && !wr_valid && in_ready && commit_ready));

  // R2
  no_spec_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cq_count == '0) |-> !wr_valid);

  // R3
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (sq_count == '0));

  // R4
  commit_move_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_req && commit_ready && sq_count != '0 && !(wr_valid && wr_ready))
      |=> (cq_count == $past(cq_count) + CW'(1)));

  // R5
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready && !flush && !(commit_req && commit_ready))
      |=> $stable(sq_count));

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready)
      |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

  // R8
  ld_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ld_hit && ld_stall));

  // R9
  empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> (!wr_valid && in_ready && sq_count == '0));
endmodule

bind store_buffer store_buffer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .flush(flush), .commit_req(commit_req), .commit_ready(commit_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_be(wr_be), .ld_hit(ld_hit), .ld_stall(ld_stall),
  .empty(empty), .sq_count(sq_count), .cq_count(cq_count)
);

// File: tb/tb_store_buffer.sv
`timescale 1ns/1ps
module tb_store_buffer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_addr = '0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_be = '0;
  logic        flush = 1'b0, commit_req = 1'b0, commit_ready;
  logic        wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_be;
  logic [31:0] ld_addr = '0;
  logic [7:0]  ld_be = '0;
  logic [63:0] ld_data;
  logic        ld_hit, ld_stall, empty;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  store_buffer #(.DEPTH(4)) dut (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] a, logic [63:0] d, logic [7:0] be);
    in_valid = 1'b1; in_addr = a; in_data = d; in_be = be;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic commit1();
    commit_req = 1'b1; tick(); commit_req = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1; tick(); flush = 1'b0;
  endtask

  task automatic take(string req, logic [31:0] a, logic [63:0] d, logic [7:0] be);
    chk({req, " wr_valid"}, 64'(wr_valid), 64'd1);
    chk({req, " wr_addr"}, 64'(wr_addr), 64'(a));
    chk({req, " wr_data"}, wr_data, d);
    chk({req, " wr_be"}, 64'(wr_be), 64'(be));
    wr_ready = 1'b1; tick(); wr_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 empty", 64'(empty), 64'd1);
    chk("R1 wr_valid", 64'(wr_valid), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    chk("R1 commit_ready", 64'(commit_ready), 64'd1);
  endtask

  task automatic t_spec_hold();
    push(32'h100, 64'hA7A6A5A4_A3A2A1A0, 8'hFF);
    wr_ready = 1'b1;
    repeat (3) tick();
    chk("R2 no write while speculative", 64'(wr_valid), 64'd0);
    wr_ready = 1'b0;
    chk("R9 empty with one store", 64'(empty), 64'd0);
    ld_addr = 32'h104; ld_be = 8'hF0; #1;
    chk("R7 upper half forwarded", ld_data, 64'hA7A6A5A4_00000000);
    chk("R8 full hit", 64'(ld_hit), 64'd1);
    do_flush();
    chk("R3 flush empties", 64'(empty), 64'd1);
    chk("R3 lookup after flush", {62'd0, ld_hit, ld_stall}, 64'd0);
  endtask

  task automatic t_commit_order();
    push(32'h200, 64'h1111_2222_3333_4444, 8'hFF);
    push(32'h208, 64'h5555_6666_7777_8888, 8'h0F);
    commit1();
    chk("R4 committed visible", 64'(wr_addr), 64'h200);
    repeat (2) tick();
    chk("R6 held under backpressure", 64'(wr_addr), 64'h200);
    take("R6 first", 32'h200, 64'h1111_2222_3333_4444, 8'hFF);
    chk("R2 second still speculative", 64'(wr_valid), 64'd0);
    commit1();
    take("R6 second", 32'h208, 64'h5555_6666_7777_8888, 8'h0F);
    chk("R9 drained", 64'(empty), 64'd1);
  endtask

  task automatic t_spec_full();
    for (int i = 0; i < 4; i++) push(32'h300 + 32'(8*i), 64'(i + 1), 8'hFF);
    chk("R5 in_ready low when full", 64'(in_ready), 64'd0);
    push(32'h3F8, 64'hDEAD, 8'hFF);
    for (int i = 0; i < 4; i++) commit1();
    for (int i = 0; i < 4; i++) take("R5 order", 32'h300 + 32'(8*i), 64'(i + 1), 8'hFF);
    chk("R5 refused store absent", 64'(wr_valid), 64'd0);
    chk("R5 buffer empty", 64'(empty), 64'd1);
  endtask

  task automatic t_cq_full();
    for (int i = 0; i < 4; i++) begin
      push(32'h400 + 32'(8*i), 64'(16 + i), 8'h3C);
      commit1();
    end
    chk("R4 commit_ready low when full", 64'(commit_ready), 64'd0);
    push(32'h4F0, 64'hBEEF, 8'hFF);
    commit1();
    do_flush();
    chk("R3 committed survives flush", 64'(wr_valid), 64'd1);
    for (int i = 0; i < 4; i++) take("R4 drain", 32'h400 + 32'(8*i), 64'(16 + i), 8'h3C);
    chk("R4 blocked commit moved nothing", 64'(empty), 64'd1);
  endtask

  task automatic t_fwd_prio();
    push(32'h500, 64'h1111_1111_1111_1111, 8'hFF);
    commit1();
    push(32'h500, 64'h2222_2222_2222_2222, 8'h0F);
    push(32'h503, 64'h3333_3333_3333_3333, 8'h03);
    ld_addr = 32'h506; ld_be = 8'hFF; #1;
    chk("R7 youngest per lane", ld_data, 64'h1111_1111_2222_3333);
    chk("R8 hit merged", 64'(ld_hit), 64'd1);
    ld_addr = 32'h508; #1;
    chk("R7 other word data", ld_data, 64'd0);
    chk("R8 no coverage", {62'd0, ld_hit, ld_stall}, 64'd0);
    do_flush();
    ld_addr = 32'h500; #1;
    chk("R7 committed only", ld_data, 64'h1111_1111_1111_1111);
    take("R6 fwd drain", 32'h500, 64'h1111_1111_1111_1111, 8'hFF);
    push(32'h500, 64'h2222_2222_2222_2222, 8'h0F);
    ld_be = 8'hFF; #1;
    chk("R8 partial stall", {62'd0, ld_hit, ld_stall}, 64'd1);
    ld_be = 8'h03; #1;
    chk("R8 narrow load hit", {62'd0, ld_hit, ld_stall}, 64'd2);
    chk("R7 narrow data", ld_data, 64'h0000_0000_0000_2222);
    ld_be = 8'h00; #1;
    chk("R8 empty mask", {62'd0, ld_hit, ld_stall}, 64'd0);
    do_flush();
  endtask

  task automatic t_flush_commit();
    push(32'h600, 64'hCAFE_0001, 8'hFF);
    push(32'h608, 64'hCAFE_0002, 8'hFF);
    in_valid = 1'b1; in_addr = 32'h610; in_data = 64'hCAFE_0003; in_be = 8'hFF;
    commit_req = 1'b1; flush = 1'b1;
    tick();
    commit_req = 1'b0; flush = 1'b0; in_valid = 1'b0;
    take("R10 oldest kept", 32'h600, 64'hCAFE_0001, 8'hFF);
    chk("R10 rest dropped", 64'(empty), 64'd1);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_spec_hold();
    t_commit_order();
    t_spec_full();
    t_cq_full();
    t_fwd_prio();
    t_flush_commit();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule